// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a processor's data-memory port and an external byte-wide static memory. It turns each internal read or write request into a fixed sequence of cycles on a multiplexed bus. One 8-bit port carries first the low address byte and then the data. A separate 8-bit port carries address bits 15..8 for the whole transfer.

An active-high latch strobe tells an external transparent latch when to capture the low address byte from the shared port. Active-low read and write strobes then move the data. The shared port is released for reads and driven for writes. A 32K-byte memory selected by address bit 15 low answers in the range 0x0000 to 0x7FFF.

The requester presents a request with a write flag, a 16-bit address and write data. It may issue a request only while the ready output is high. It receives a one-cycle done pulse when the transfer finishes, and read data on the same cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the latch strobe is low, the read and write strobes are high, the shared port is not driven (enable low), ready is high and done is low.
- R2: In the first cycle after a request is accepted, the latch strobe is high, the shared port drives address bits 7..0 with its enable high, and the high port shows address bits 15..8. The latch strobe stays high for exactly one cycle per transfer.
- R3: In the cycle after the latch strobe falls, the shared port still drives the low address byte. The high port holds address bits 15..8 unchanged from the address cycle to the end of the transfer.
- R4: During a read, the shared port is not driven from the third cycle of the transfer to its end. The read strobe is low for exactly STROBE_CYC cycles. The byte on the port input in the last read-strobe-low cycle appears on rspRdata with done.
- R5: During a write, the shared port drives the write data from the third cycle, for every write-strobe-low cycle, and for one cycle after the write strobe rises.
- R6: The read and write strobes are never low together. Both are high whenever ready is high. A read never lowers the write strobe, and a write never lowers the read strobe.
- R7: Done is high for exactly one cycle, the last cycle of the transfer. A transfer lasts STROBE_CYC+4 cycles from acceptance, and ready returns high in the following cycle.
- R8: A request presented while ready is low is ignored. It does not restart, extend or alter the transfer in progress, and it does not start a second transfer.
- R9: Because the high port carries address bit 15, a memory decoded on bit 15 low does not answer in 0x8000 to 0xFFFF. A write there does not change the location with bit 15 cleared, and a read there returns the bus pull-up value 0xFF.
- R10: rspRdata keeps its value through write transfers and changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request; accepted only while reqReady is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Byte address |
| reqWdata | input | 8 | Write data |
| reqReady | output | 1 | Controller idle, a request will be accepted |
| rspRdata | output | 8 | Last read byte |
| rspDone | output | 1 | One-cycle pulse at end of a transfer |
| busAdOut | output | 8 | Shared address/data port, output value |
| busAdIn | input | 8 | Shared address/data port, input value |
| busAdOe | output | 1 | Output enable of the shared port |
| busAddrHi | output | 8 | Address bits 15..8 |
| busAle | output | 1 | Active-high address latch strobe |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |

## Verification
A wrong sequencer state shows up on the bus pins within the same cycle. Possible symptoms are a second latch pulse, a strobe of the wrong length, a strobe of the wrong direction, or the port driven while the memory drives it. A miscounted strobe timer moves the done pulse away from cycle STROBE_CYC+4. A lost or mis-latched address register does not show on the pins directly. It shows when the latched byte or the high port is wrong, or when the memory later returns a byte to the wrong address. That only appears on the read that follows, so each write is read back.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LATCH,
    ST_TURN,
    ST_STROBE,
    ST_RECOVER
  } busState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // take a new request into the address/data registers
    logic ale;        // latch strobe level
    logic driveAddr;  // shared port carries the low address byte
    logic driveData;  // shared port carries the write byte
    logic rdLow;      // read strobe asserted
    logic wrLow;      // write strobe asserted
    logic capture;    // sample the shared port into the read register
    logic done;       // last cycle of the transfer
  } busCtl_t;

endpackage

// File: rtl/xbus_ctrl_fsm.sv
module xbus_ctrl_fsm
  import xbus_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    ready,
  output busCtl_t ctl
);

  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  busState_t       state, stateNext;
  logic            opWrite;
  logic [CNT_W-1:0] strobeCnt;
  logic            lastStrobe;

  assign lastStrobe = (strobeCnt == CNT_LAST);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (reqValid) stateNext = ST_ADDR;
      ST_ADDR:    stateNext = ST_LATCH;
      ST_LATCH:   stateNext = ST_TURN;
      ST_TURN:    stateNext = ST_STROBE;
      ST_STROBE:  if (lastStrobe) stateNext = ST_RECOVER;
      ST_RECOVER: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opWrite   <= 1'b0;
      strobeCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && reqValid) opWrite <= reqWrite;
      if (state == ST_STROBE && !lastStrobe) strobeCnt <= strobeCnt + 1'b1;
      else strobeCnt <= '0;
    end
  end

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE:    ctl.load = reqValid;
      ST_ADDR: begin
        ctl.ale       = 1'b1;
        ctl.driveAddr = 1'b1;
      end
      ST_LATCH:   ctl.driveAddr = 1'b1;
      ST_TURN:    ctl.driveData = opWrite;
      ST_STROBE: begin
        ctl.rdLow     = !opWrite;
        ctl.wrLow     = opWrite;
        ctl.driveData = opWrite;
        ctl.capture   = !opWrite && lastStrobe;
      end
      ST_RECOVER: begin
        ctl.driveData = opWrite;
        ctl.done      = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  assign ready = (state == ST_IDLE);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.rdLow && ctl.wrLow)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !(ctl.rdLow || ctl.wrLow || ctl.ale)); // R6
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ale |=> !ctl.ale); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> (!ctl.done && ready)); // R7
  AST_CAPTURE_IN_RD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> ctl.done); // R4

endmodule

// File: rtl/xbus_ctrl_dp.sv
module xbus_ctrl_dp
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busAdIn,
  output logic [DATA_W-1:0] busAdOut,
  output logic              busAdOe,
  output logic [ADDR_W-DATA_W-1:0] busAddrHi,
  output logic              busAle,
  output logic              busRdN,
  output logic              busWrN,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) rdataQ <= busAdIn;
    end
  end

  always_comb begin
    if (ctl.driveAddr)      busAdOut = addrQ[DATA_W-1:0];
    else if (ctl.driveData) busAdOut = wdataQ;
    else                    busAdOut = '0;
  end

  assign busAdOe   = ctl.driveAddr | ctl.driveData;
  assign busAddrHi = addrQ[ADDR_W-1:DATA_W];
  assign busAle    = ctl.ale;
  assign busRdN    = ~ctl.rdLow;
  assign busWrN    = ~ctl.wrLow;
  assign rspRdata  = rdataQ;
  assign rspDone   = ctl.done;

  AST_RD_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> !busAdOe); // R4
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !busWrN |-> (busAdOe && busAdOut == wdataQ)); // R5
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWrN) |-> busAdOe); // R5
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !busAle && !$past(ctl.load)) |-> $stable(busAddrHi)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.capture) |-> $stable(rspRdata)); // R10

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed DATA_W");
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] busAdOut,
  input  logic [DATA_W-1:0] busAdIn,
  output logic              busAdOe,
  output logic [ADDR_W-DATA_W-1:0] busAddrHi,
  output logic              busAle,
  output logic              busRdN,
  output logic              busWrN
);

  busCtl_t ctl;

  xbus_ctrl_fsm #(.STROBE_CYC(STROBE_CYC)) fsm_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .ready    (reqReady),
    .ctl      (ctl)
  );

  xbus_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busAdIn   (busAdIn),
    .busAdOut  (busAdOut),
    .busAdOe   (busAdOe),
    .busAddrHi (busAddrHi),
    .busAle    (busAle),
    .busRdN    (busRdN),
    .busWrN    (busWrN),
    .rspRdata  (rspRdata),
    .rspDone   (rspDone)
  );

  AST_BUSY_NO_ALE: assert property (@(posedge clk) disable iff (!rstN)
    (busAle && !reqReady) |=> (!busAle && !reqReady)); // R8

endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STROBE_CYC = 2;
  localparam int SEQ_LEN    = STROBE_CYC + 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspDone, busAdOe, busAle, busRdN, busWrN;
  logic [7:0]  rspRdata, busAdOut, busAdIn, busAddrHi;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl #(.STROBE_CYC(STROBE_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspRdata(rspRdata), .rspDone(rspDone), .busAdOut(busAdOut),
    .busAdIn(busAdIn), .busAdOe(busAdOe), .busAddrHi(busAddrHi),
    .busAle(busAle), .busRdN(busRdN), .busWrN(busWrN)
  );

  // external transparent latch and 32K memory (bit 15 low selects), 1K modelled
  logic [7:0] latchLo;
  logic [7:0] mem [0:1023];

  always_latch if (busAle) latchLo = busAdOut;

  assign busAdIn = (!busRdN && !busAddrHi[7]) ? mem[{busAddrHi[1:0], latchLo}] : 8'hFF;

  always @(posedge busWrN)
    if (rstN && !busAddrHi[7]) mem[{busAddrHi[1:0], latchLo}] = busAdOut;

  function automatic logic [7:0] initVal(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one transfer; pins checked every cycle at the falling edge
  task automatic transfer(input logic wr, input logic [15:0] addr, input logic [7:0] wd,
                          input logic holdBusy, output logic [7:0] rd);
    int n = 0;
    int aleCnt = 0;
    int strobeCnt = 0;
    logic prevWrLow = 1'b0;
    logic seenDone = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    if (!holdBusy) reqValid = 1'b0;
    rd = 8'h00;
    while (!seenDone && n < 40) begin
      n++;
      if (busAle) aleCnt++;
      if (n == 1) begin
        check(busAle && busAdOe && busAdOut == addr[7:0], "R2", busAdOut, addr[7:0]);
        check(busAddrHi == addr[15:8], "R2", busAddrHi, addr[15:8]);
      end
      if (n == 2) begin
        check(!busAle && busAdOe && busAdOut == addr[7:0], "R3", busAdOut, addr[7:0]);
        if (holdBusy) begin reqAddr = addr ^ 16'h0033; reqWdata = ~wd; reqWrite = ~wr; end
      end
      if (n >= 1) check(busAddrHi == addr[15:8], "R3", busAddrHi, addr[15:8]);
      check(busRdN || busWrN, "R6", {busRdN, busWrN}, 2'b11);
      if (n >= 3 && !wr) check(!busAdOe && busWrN, "R4", busAdOe, 0);
      if (n >= 3 && wr) begin
        check(busAdOe && busAdOut == wd && busRdN, "R5", busAdOut, wd);
      end
      if (!busRdN || !busWrN) begin
        strobeCnt++;
        check(latchLo == addr[7:0], "R3", latchLo, addr[7:0]);
      end
      if (prevWrLow && busWrN) check(busAdOe && busAdOut == wd, "R5", busAdOut, wd);
      prevWrLow = !busWrN;
      if (rspDone) begin
        seenDone = 1'b1;
        check(n == SEQ_LEN, "R7", n, SEQ_LEN);
        rd = rspRdata;
        if (holdBusy) reqValid = 1'b0;
      end
      @(negedge clk);
    end
    check(seenDone, "R7", seenDone, 1);
    check(aleCnt == 1, wr ? "R2" : "R2", aleCnt, 1);
    check(strobeCnt == STROBE_CYC, wr ? "R5" : "R4", strobeCnt, STROBE_CYC);
    check(reqReady && busRdN && busWrN && !rspDone && !busAle, "R7", reqReady, 1);
    check(!busAle, "R8", busAle, 0);
  endtask

  // vectors: write flag, address, write data, expected read byte
  localparam int NVEC = 10;
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 16'h0012, 8'hA5, 8'h00},
    {1'b0, 16'h0012, 8'h00, 8'hA5},
    {1'b1, 16'h7F34, 8'h3C, 8'h00},
    {1'b0, 16'h7F34, 8'h00, 8'h3C},
    {1'b0, 16'h0100, 8'h00, 8'h5A},
    {1'b1, 16'h9234, 8'h77, 8'h00},
    {1'b0, 16'h1234, 8'h00, 8'h6E},
    {1'b0, 16'h8012, 8'h00, 8'hFF},
    {1'b1, 16'h03FF, 8'h00, 8'h00},
    {1'b0, 16'h03FF, 8'h00, 8'h00}
  };

  initial begin
    logic [7:0] rd;
    logic [7:0] keep;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busAle && busRdN && busWrN && !busAdOe && reqReady && !rspDone, "R1",
          {busAle, busRdN, busWrN, busAdOe, reqReady, rspDone}, 6'b011010);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && busRdN && busWrN, "R6", {reqReady, busRdN, busWrN}, 3'b111);

    for (int v = 0; v < NVEC; v++) begin
      transfer(VEC[v][32], VEC[v][31:16], VEC[v][15:8], 1'b0, rd);
      if (!VEC[v][32]) check(rd == VEC[v][7:0], (v >= 5) ? "R9" : "R4", rd, VEC[v][7:0]);
    end

    // R10: read, then a write must not move rspRdata
    transfer(1'b0, 16'h0012, 8'h00, 1'b0, rd);
    keep = rspRdata;
    transfer(1'b1, 16'h0020, 8'hC3, 1'b0, rd);
    check(rspRdata == keep, "R10", rspRdata, keep);

    // R8: request held and changed while busy is ignored
    transfer(1'b1, 16'h0055, 8'h11, 1'b1, rd);
    check(reqReady && !busAle, "R8", busAle, 0);
    transfer(1'b0, 16'h0055, 8'h00, 1'b0, rd);
    check(rd == 8'h11, "R8", rd, 8'h11);
    transfer(1'b0, 16'h0066, 8'h00, 1'b0, rd);
    check(rd == initVal(16'h0066), "R8", rd, initVal(16'h0066));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule